// File: doc/BRIEF.md
# DMA Channel Interrupt and Loop Control Register Bank

This block is the shared register bank of a multi-channel DMA controller. A simple 32-bit register bus reaches it: one write strobe, a byte address, write data, and a read data path that follows the address in the same cycle. Each channel has a set of configuration words: a buffer address, two length fields, a control word and a line width. The block stores these words and drives them to the channel address engines. The bank also holds the state that all channels share: which channels have a pending event, which of them may raise the interrupt, and which of them run a looping ring buffer.

The channel engines report each completed transfer and each half-buffer crossing on one event line per channel. The bank latches these reports into a sticky status vector. It masks that vector with the enable vector and combines the result into one interrupt line. Software acknowledges a channel by writing a one to its status bit. The interrupt enable and the loop control each have a companion clear address, so software can stop one channel without a read-modify-write. An invalidate address sends a one-cycle abort to the chosen channel engines.

Top module: `dmac_ctl_regs`

## Requirements
- R1: Channel c's address, x-length, y-length and control words sit at byte offsets c*0x10 + 0x0, 0x4, 0x8 and 0xC. A write stores all 32 bits, a read returns them, and the stored word drives slice c of the matching cfg output.
- R2: Channel c's width word sits at byte offset 0x100 + 4*c. It is written, read and driven in the same way as the R1 words.
- R3: A pulse on ev_done[c] or ev_half[c] sets status bit c in the cycle after the pulse. The bit then stays set until software clears it.
- R4: The status register is at 0x144 and reads back in bits [NUM_CH-1:0]. Writing 1 to bit c clears status bit c, and writing 0 leaves it unchanged. If an event for channel c arrives in the same cycle as that clear, the bit stays set.
- R5: The enable register at 0x148 takes the written value. A write to 0x14C clears every enable bit written as 1 and leaves the other enable bits unchanged.
- R6: The irq output is high exactly when some channel has both its status bit and its enable bit set. It follows register changes with no further delay.
- R7: The loop register at 0x150 takes the written value. loop_run[c] is high only when bits c and c+16 of that register are both set.
- R8: A write to 0x15C clears every loop bit written as 1, which pauses the affected channels. Writing both bits again at 0x150 resumes a channel.
- R9: Writing 1 to bit c at 0x140 raises ch_abort[c] for exactly one cycle, the cycle after the write. A read of 0x140 returns zero.
- R10: A read of 0x14C returns the enable register. A read of 0x15C returns the loop register.
- R11: Every other offset (for example 0x154, 0x158 and anything above 0x15C) reads as zero. A write to such an offset changes no register.
- R12: After reset, all registers are zero, irq is low, loop_run is zero and ch_abort is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 9 | Byte address (bits [1:0] ignored) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ev_done | input | NUM_CH | Per-channel transfer-complete pulse |
| ev_half | input | NUM_CH | Per-channel half-buffer pulse |
| irq | output | 1 | Combined interrupt |
| loop_run | output | NUM_CH | Loop mode active per channel |
| ch_abort | output | NUM_CH | One-cycle invalidate pulse per channel |
| cfg_addr | output | NUM_CH*32 | Buffer address word per channel |
| cfg_xlen | output | NUM_CH*32 | X-length word per channel |
| cfg_ylen | output | NUM_CH*32 | Y-length word per channel |
| cfg_ctrl | output | NUM_CH*32 | Control word per channel |
| cfg_width | output | NUM_CH*32 | Line width word per channel |

## Verification
The bench builds the block with the default NUM_CH of 16. This fills the loop register completely, so the pair for channel 15 sits at bits 15 and 31, and the last channel word and width word land at 0xF0 to 0xFC and 0x13C. These are the top edges of the decode, and a wrong bit pairing or a wrong stride cannot be missed. With all channels present, every offset below 0x140 is a defined register. Undefined reads are therefore tested at the gaps 0x154 and 0x158 and in the space above 0x15C.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int unsigned MAX_CH      = 16;
  localparam int unsigned LOOP_HI_POS = 16;

  typedef enum logic [3:0] {
    RK_NONE,
    RK_CH_ADDR,
    RK_CH_XLEN,
    RK_CH_YLEN,
    RK_CH_CTRL,
    RK_WIDTH,
    RK_INVAL,
    RK_STAT,
    RK_EN,
    RK_EN_CLR,
    RK_LOOP,
    RK_LOOP_CLR
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [3:0]  ch;
  } reg_sel_t;

  // Byte address to register kind and channel.
  function automatic reg_sel_t decode_addr(input logic [8:0] a, input int unsigned num_ch);
    reg_sel_t s;
    s.kind = RK_NONE;
    s.ch   = a[7:4];
    if (!a[8]) begin
      if (32'(a[7:4]) < num_ch) begin
        case (a[3:2])
          2'd0:    s.kind = RK_CH_ADDR;
          2'd1:    s.kind = RK_CH_XLEN;
          2'd2:    s.kind = RK_CH_YLEN;
          default: s.kind = RK_CH_CTRL;
        endcase
      end
    end else if (a[7:6] == 2'b00) begin
      s.ch = a[5:2];
      if (32'(a[5:2]) < num_ch) s.kind = RK_WIDTH;
    end else begin
      case (a[7:2])
        6'h10:   s.kind = RK_INVAL;
        6'h11:   s.kind = RK_STAT;
        6'h12:   s.kind = RK_EN;
        6'h13:   s.kind = RK_EN_CLR;
        6'h14:   s.kind = RK_LOOP;
        6'h17:   s.kind = RK_LOOP_CLR;
        default: s.kind = RK_NONE;
      endcase
    end
    return s;
  endfunction

  // Sticky bit update: clear mask applies first, set mask overrides.
  function automatic logic [31:0] w1c_merge(input logic [31:0] cur,
                                            input logic [31:0] clr,
                                            input logic [31:0] set);
    return (cur & ~clr) | set;
  endfunction

  // Bits kept in the loop register for the configured channel count.
  function automatic logic [31:0] loop_bit_mask(input int unsigned num_ch);
    logic [31:0] m;
    m = '0;
    for (int unsigned i = 0; i < MAX_CH; i++) begin
      if (i < num_ch) begin
        m[i]               = 1'b1;
        m[i + LOOP_HI_POS] = 1'b1;
      end
    end
    return m;
  endfunction

  // A channel loops only when both of its paired bits are set.
  function automatic logic [15:0] loop_pairs(input logic [31:0] lp);
    return lp[15:0] & lp[31:16];
  endfunction

  function automatic logic any_pending(input logic [31:0] stat,
                                       input logic [31:0] en);
    return |(stat & en);
  endfunction

endpackage

// File: rtl/dmac_reg_decode.sv
module dmac_reg_decode
  import dmac_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic [8:0] addr,
  output reg_sel_t   sel
);

  logic unused_low_bits;
  assign unused_low_bits = ^addr[1:0];

  assign sel = decode_addr(addr, NUM_CH);

endmodule

// File: rtl/dmac_chan_cfg.sv
module dmac_chan_cfg
  import dmac_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  reg_sel_t               sel,
  input  logic [31:0]            wdata,
  output logic [NUM_CH*32-1:0]   cfg_addr,
  output logic [NUM_CH*32-1:0]   cfg_xlen,
  output logic [NUM_CH*32-1:0]   cfg_ylen,
  output logic [NUM_CH*32-1:0]   cfg_ctrl,
  output logic [NUM_CH*32-1:0]   cfg_width,
  output logic [31:0]            rd
);

  localparam int unsigned WORD_W = 32;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic        hit;
    logic [31:0] addr_q, xlen_q, ylen_q, ctrl_q, width_q;

    assign hit = wr && (sel.ch == 4'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q  <= '0;
        xlen_q  <= '0;
        ylen_q  <= '0;
        ctrl_q  <= '0;
        width_q <= '0;
      end else if (hit) begin
        case (sel.kind)
          RK_CH_ADDR: addr_q  <= wdata;
          RK_CH_XLEN: xlen_q  <= wdata;
          RK_CH_YLEN: ylen_q  <= wdata;
          RK_CH_CTRL: ctrl_q  <= wdata;
          RK_WIDTH:   width_q <= wdata;
          default: ;
        endcase
      end
    end

    assign cfg_addr [c*WORD_W +: WORD_W] = addr_q;
    assign cfg_xlen [c*WORD_W +: WORD_W] = xlen_q;
    assign cfg_ylen [c*WORD_W +: WORD_W] = ylen_q;
    assign cfg_ctrl [c*WORD_W +: WORD_W] = ctrl_q;
    assign cfg_width[c*WORD_W +: WORD_W] = width_q;
  end

  always_comb begin
    rd = '0;
    for (int c = 0; c < int'(NUM_CH); c++) begin
      if (sel.ch == 4'(c)) begin
        case (sel.kind)
          RK_CH_ADDR: rd = cfg_addr [c*WORD_W +: WORD_W];
          RK_CH_XLEN: rd = cfg_xlen [c*WORD_W +: WORD_W];
          RK_CH_YLEN: rd = cfg_ylen [c*WORD_W +: WORD_W];
          RK_CH_CTRL: rd = cfg_ctrl [c*WORD_W +: WORD_W];
          RK_WIDTH:   rd = cfg_width[c*WORD_W +: WORD_W];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dmac_irq_ctrl.sv
module dmac_irq_ctrl
  import dmac_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  reg_sel_t          sel,
  input  logic [31:0]       wdata,
  input  logic [NUM_CH-1:0] ev_done,
  input  logic [NUM_CH-1:0] ev_half,
  output logic [NUM_CH-1:0] status,
  output logic [NUM_CH-1:0] enable,
  output logic              irq,
  output logic [31:0]       rd
);

  logic [NUM_CH-1:0] ev_any;
  logic [31:0]       stat_clr, stat_nx, en_nx;
  logic              unused_bits;

  assign ev_any   = ev_done | ev_half;
  assign stat_clr = (wr && sel.kind == RK_STAT) ? wdata : '0;
  assign stat_nx  = w1c_merge(32'(status), stat_clr, 32'(ev_any));

  always_comb begin
    en_nx = 32'(enable);
    if (wr && sel.kind == RK_EN)     en_nx = wdata;
    if (wr && sel.kind == RK_EN_CLR) en_nx = 32'(enable) & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= stat_nx[NUM_CH-1:0];
      enable <= en_nx[NUM_CH-1:0];
    end
  end

  assign irq = any_pending(32'(status), 32'(enable));

  always_comb begin
    case (sel.kind)
      RK_STAT:          rd = 32'(status);
      RK_EN, RK_EN_CLR: rd = 32'(enable);
      default:          rd = '0;
    endcase
  end

  assign unused_bits = ^{stat_nx, en_nx, sel.ch};

endmodule

// File: rtl/dmac_loop_ctrl.sv
module dmac_loop_ctrl
  import dmac_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  reg_sel_t          sel,
  input  logic [31:0]       wdata,
  output logic [NUM_CH-1:0] loop_run,
  output logic [NUM_CH-1:0] abort,
  output logic [31:0]       rd
);

  localparam logic [31:0] LOOP_MASK = loop_bit_mask(NUM_CH);

  logic [31:0] loop_q;
  logic [15:0] pairs;
  logic        unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= '0;
      abort  <= '0;
    end else begin
      if (wr && sel.kind == RK_LOOP)          loop_q <= wdata & LOOP_MASK;
      else if (wr && sel.kind == RK_LOOP_CLR) loop_q <= loop_q & ~wdata;
      abort <= (wr && sel.kind == RK_INVAL) ? wdata[NUM_CH-1:0] : '0;
    end
  end

  assign pairs    = loop_pairs(loop_q);
  assign loop_run = pairs[NUM_CH-1:0];

  always_comb begin
    case (sel.kind)
      RK_LOOP, RK_LOOP_CLR: rd = loop_q;
      default:              rd = '0;
    endcase
  end

  assign unused_bits = ^{pairs, wdata, sel.ch};

endmodule

// File: rtl/dmac_ctl_regs.sv
module dmac_ctl_regs
  import dmac_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [8:0]            reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [NUM_CH-1:0]     ev_done,
  input  logic [NUM_CH-1:0]     ev_half,
  output logic                  irq,
  output logic [NUM_CH-1:0]     loop_run,
  output logic [NUM_CH-1:0]     ch_abort,
  output logic [NUM_CH*32-1:0]  cfg_addr,
  output logic [NUM_CH*32-1:0]  cfg_xlen,
  output logic [NUM_CH*32-1:0]  cfg_ylen,
  output logic [NUM_CH*32-1:0]  cfg_ctrl,
  output logic [NUM_CH*32-1:0]  cfg_width
);

  reg_sel_t          sel;
  logic [31:0]       rd_cfg, rd_irq, rd_loop;
  logic [NUM_CH-1:0] status_q, enable_q;

  dmac_reg_decode #(.NUM_CH(NUM_CH)) u_dec (
    .addr (reg_addr),
    .sel  (sel)
  );

  dmac_chan_cfg #(.NUM_CH(NUM_CH)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .sel       (sel),
    .wdata     (reg_wdata),
    .cfg_addr  (cfg_addr),
    .cfg_xlen  (cfg_xlen),
    .cfg_ylen  (cfg_ylen),
    .cfg_ctrl  (cfg_ctrl),
    .cfg_width (cfg_width),
    .rd        (rd_cfg)
  );

  dmac_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .sel     (sel),
    .wdata   (reg_wdata),
    .ev_done (ev_done),
    .ev_half (ev_half),
    .status  (status_q),
    .enable  (enable_q),
    .irq     (irq),
    .rd      (rd_irq)
  );

  dmac_loop_ctrl #(.NUM_CH(NUM_CH)) u_loop (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .sel      (sel),
    .wdata    (reg_wdata),
    .loop_run (loop_run),
    .abort    (ch_abort),
    .rd       (rd_loop)
  );

  // Each source returns zero when its registers are not addressed.
  assign reg_rdata = rd_cfg | rd_irq | rd_loop;

endmodule

// File: rtl/dmac_ctl_checker.sv
module dmac_ctl_checker #(
  parameter int unsigned NUM_CH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [8:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [NUM_CH-1:0] ev_done,
  input logic [NUM_CH-1:0] ev_half,
  input logic              irq,
  input logic [NUM_CH-1:0] loop_run,
  input logic [NUM_CH-1:0] ch_abort,
  input logic [NUM_CH-1:0] status_q,
  input logic [NUM_CH-1:0] enable_q
);

  assert_event_sets_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev_done | ev_half)) |=>
      ((status_q & $past(ev_done | ev_half)) == $past(ev_done | ev_half)));

  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 9'h144) |=>
      ((status_q & $past(reg_wdata[NUM_CH-1:0] & ~(ev_done | ev_half))) == '0));

  assert_enable_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 9'h14C) |=>
      ((enable_q & $past(reg_wdata[NUM_CH-1:0])) == '0));

  assert_irq_needs_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|enable_q) && (|status_q)));

  assert_loop_clear_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 9'h15C) |=>
      ((loop_run & $past(reg_wdata[NUM_CH-1:0] | reg_wdata[16 +: NUM_CH])) == '0));

  assert_abort_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_abort != '0) |-> ($past(reg_wr) && $past(reg_addr[8:2]) == 7'h50));

endmodule

bind dmac_ctl_regs dmac_ctl_checker #(.NUM_CH(NUM_CH)) u_ctl_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .ev_done   (ev_done),
  .ev_half   (ev_half),
  .irq       (irq),
  .loop_run  (loop_run),
  .ch_abort  (ch_abort),
  .status_q  (status_q),
  .enable_q  (enable_q)
);

// File: tb/test_dmac_ctl_regs.sv
`timescale 1ns/1ps
module test_dmac_ctl_regs;

  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [8:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  ev_done = '0;
  logic [N-1:0]  ev_half = '0;
  logic          irq;
  logic [N-1:0]  loop_run, ch_abort;
  logic [N*32-1:0] cfg_addr, cfg_xlen, cfg_ylen, cfg_ctrl, cfg_width;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] m_cfg [N][5];
  logic [N-1:0] m_stat, m_en, m_abort;
  logic [31:0]  m_loop;

  always #5 clk = ~clk;

  dmac_ctl_regs #(.NUM_CH(N)) i_dmac_ctl_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_done(ev_done),
    .ev_half(ev_half), .irq(irq), .loop_run(loop_run), .ch_abort(ch_abort),
    .cfg_addr(cfg_addr), .cfg_xlen(cfg_xlen), .cfg_ylen(cfg_ylen),
    .cfg_ctrl(cfg_ctrl), .cfg_width(cfg_width)
  );

  function automatic logic [31:0] m_read(input logic [8:0] a);
    if (a < 9'h100) return m_cfg[a[7:4]][a[3:2]];
    if (a < 9'h140) return m_cfg[a[5:2]][4];
    case (a)
      9'h144:         return 32'(m_stat);
      9'h148, 9'h14C: return 32'(m_en);
      9'h150, 9'h15C: return m_loop;
      default:        return 32'h0;
    endcase
  endfunction

  function automatic void m_update(input logic wr, input logic [8:0] a,
                                   input logic [31:0] d, input logic [N-1:0] ev);
    logic [N-1:0] clr;
    clr = (wr && a == 9'h144) ? d[N-1:0] : '0;
    m_stat = (m_stat & ~clr) | ev;
    m_abort = (wr && a == 9'h140) ? d[N-1:0] : '0;
    if (wr) begin
      if (a < 9'h100) m_cfg[a[7:4]][a[3:2]] = d;
      else if (a < 9'h140) m_cfg[a[5:2]][4] = d;
      else case (a)
        9'h148: m_en = d[N-1:0];
        9'h14C: m_en = m_en & ~d[N-1:0];
        9'h150: m_loop = d;
        9'h15C: m_loop = m_loop & ~d;
        default: ;
      endcase
    end
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [8:0] a, input logic [31:0] d,
                      input logic [N-1:0] dn, input logic [N-1:0] hf);
    reg_wr = wr; reg_addr = a; reg_wdata = d; ev_done = dn; ev_half = hf;
    @(posedge clk);
    m_update(wr, a, d, dn | hf);
    @(negedge clk);
    reg_wr = 1'b0; ev_done = '0; ev_half = '0;
  endtask

  task automatic wr_reg(input logic [8:0] a, input logic [31:0] d);
    step(1'b1, a, d, '0, '0);
  endtask

  task automatic check_read(input string req, input logic [8:0] a);
    reg_addr = a;
    #1;
    check(req, reg_rdata, m_read(a));
  endtask

  task automatic check_outs(input string req);
    check({req, " irq R6"}, 32'(irq), 32'(|(m_stat & m_en)));
    check({req, " loop_run R7"}, 32'(loop_run), 32'(m_loop[15:0] & m_loop[31:16]));
    check({req, " ch_abort R9"}, 32'(ch_abort), 32'(m_abort));
  endtask

  function automatic logic [8:0] rand_addr();
    int k;
    k = int'($urandom % 10);
    case (k)
      0, 1, 2: return {1'b0, 4'($urandom), 2'($urandom), 2'b00};
      3:       return 9'h100 + 9'({4'($urandom), 2'b00});
      4:       return 9'h144;
      5:       return 9'h148;
      6:       return 9'h14C;
      7:       return ($urandom % 2) ? 9'h150 : 9'h15C;
      8:       return ($urandom % 2) ? 9'h140 : 9'h154;
      default: return ($urandom % 2) ? 9'h158 : 9'h1E8;
    endcase
  endfunction

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < N; c++) for (int k = 0; k < 5; k++) m_cfg[c][k] = '0;
    m_stat = '0; m_en = '0; m_abort = '0; m_loop = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    check("R12 irq", 32'(irq), 32'h0);
    check("R12 loop_run", 32'(loop_run), 32'h0);
    check("R12 ch_abort", 32'(ch_abort), 32'h0);
    check_read("R12 status", 9'h144);
    check_read("R12 enable", 9'h148);
    check_read("R12 loop", 9'h150);

    // R1, R2: channel words, including the last channel
    wr_reg(9'h000, 32'hA5A5_0001);
    wr_reg(9'h0F4, 32'h1234_5678);
    wr_reg(9'h0FC, 32'hCAFE_0F0F);
    wr_reg(9'h13C, 32'h0000_0040);
    wr_reg(9'h108, 32'h0000_0011);
    check_read("R1 ch0 addr", 9'h000);
    check_read("R1 ch15 xlen", 9'h0F4);
    check_read("R1 ch15 ctrl", 9'h0FC);
    check_read("R2 ch15 width", 9'h13C);
    check_read("R2 ch2 width", 9'h108);
    check("R1 cfg_xlen ch15", cfg_xlen[15*32 +: 32], 32'h1234_5678);
    check("R1 cfg_addr ch0", cfg_addr[31:0], 32'hA5A5_0001);
    check("R2 cfg_width ch2", cfg_width[2*32 +: 32], 32'h0000_0011);

    // R3, R6: event latches with enable off, irq stays low
    step(1'b0, 9'h0, 32'h0, 16'h0008, 16'h0);
    check_read("R3 status after done", 9'h144);
    check_outs("R3 masked");
    step(1'b0, 9'h0, 32'h0, 16'h0, 16'h8000);
    check_read("R3 status after half ch15", 9'h144);
    wr_reg(9'h148, 32'h0000_0008);
    check_outs("R6 enabled");
    check("R6 irq high", 32'(irq), 32'h1);
    // R4: writing zero leaves bits, collision keeps bit set
    wr_reg(9'h144, 32'h0);
    check_read("R4 write zero", 9'h144);
    step(1'b1, 9'h144, 32'h0000_0008, 16'h0, 16'h0008);
    check_read("R4 event wins", 9'h144);
    check("R4 bit3 kept", reg_rdata & 32'h8, 32'h8);
    wr_reg(9'h144, 32'h0000_8008);
    check_read("R4 cleared", 9'h144);
    check_outs("R4 after clear");

    // R5, R10: enable clear alias
    wr_reg(9'h148, 32'h0000_FFFF);
    wr_reg(9'h14C, 32'h0000_00F0);
    check_read("R5 enable after clear", 9'h148);
    check("R5 enable value", reg_rdata, 32'h0000_FF0F);
    check_read("R10 enable alias read", 9'h14C);

    // R7, R8, R10: loop pairing, pause, resume
    wr_reg(9'h150, 32'h0000_8000);
    check("R7 single bit no run", 32'(loop_run), 32'h0);
    wr_reg(9'h150, 32'h8000_8000);
    check("R7 pair runs ch15", 32'(loop_run), 32'h8000);
    wr_reg(9'h15C, 32'h8000_0000);
    check("R8 paused", 32'(loop_run), 32'h0);
    check_read("R8 loop after clear", 9'h150);
    check_read("R10 loop alias read", 9'h15C);
    wr_reg(9'h150, 32'h8001_8001);
    check("R8 resumed", 32'(loop_run), 32'h8001);

    // R9: invalidate pulse
    wr_reg(9'h140, 32'h0000_8001);
    check("R9 abort pulse", 32'(ch_abort), 32'h8001);
    step(1'b0, 9'h0, 32'h0, '0, '0);
    check("R9 abort single cycle", 32'(ch_abort), 32'h0);
    check_read("R9 invalidate reads zero", 9'h140);

    // R11: undefined offsets
    wr_reg(9'h154, 32'hFFFF_FFFF);
    wr_reg(9'h158, 32'hFFFF_FFFF);
    wr_reg(9'h1F0, 32'hFFFF_FFFF);
    check_read("R11 read 0x154", 9'h154);
    check_read("R11 read 0x1F0", 9'h1F0);
    check_read("R11 enable untouched", 9'h148);
    check_read("R11 loop untouched", 9'h150);
    check_read("R11 status untouched", 9'h144);
    check_outs("R11 outputs");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [8:0]   a;
      logic [N-1:0] dn, hf;
      a  = rand_addr();
      dn = ($urandom % 3 == 0) ? N'($urandom & $urandom) : '0;
      hf = ($urandom % 4 == 0) ? N'($urandom & $urandom) : '0;
      step(($urandom % 4) != 0, a, $urandom, dn, hf);
      check_outs("R3/R4/R5/R8 random");
      check_read("R1/R2/R10/R11 random read", rand_addr());
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule